// File: doc/BRIEF.md
# Dependence-Aware Instruction Steering Unit

This block sits between rename and a pool of in-order execution units. Each unit owns a few small FIFO instruction buffers, and the units are grouped four to a cluster. For every renamed instruction the block picks one buffer. The pick follows a fixed preference. The first choice is the slot directly behind the instruction that produces one of its sources, so a dependence chain stays in one FIFO. The second choice is an empty buffer in the same cluster as a producer. If neither exists, the instruction stalls rather than being sent to a distant cluster.

The block keeps one entry per architectural register. Each entry holds a valid bit, the buffer of the newest in-flight writer, and a flag that records whether a consumer has already been queued behind that writer. It also keeps a count of entries in each buffer, which gives an empty vector and a full vector, plus the register written by the last instruction placed in each buffer. The decision is combinational on the current inputs and registered state, and all state advances on the next rising clock edge. When a consumer lands in a unit other than its producer's, the block raises a notice naming both units, so the producer's unit can forward its result.

Top module: `dep_steer`

## Requirements
- R1: After reset every buffer is empty and no register has an in-flight producer. With in_valid low, both steer_valid and stall are 0. The first instruction is steered to buffer 0.
- R2: A source is outstanding when its valid bit is set and its register has a live entry. With no outstanding source, the instruction goes to the lowest-indexed empty buffer. If no buffer is empty, it stalls.
- R3: The slot behind a producer is free when three conditions hold: the entry's consumer flag is clear, the producer is the last instruction placed in its buffer, and that buffer is not full. With one outstanding producer whose slot is free, the instruction goes into the producer's buffer, and the consumer flag is then set. A later reader of the same register therefore does not go behind that producer.
- R4: With one outstanding producer whose slot is not free, the instruction goes to the lowest-indexed empty buffer in the producer's cluster. Buffer b belongs to unit b / BUFS_PER_EU and to cluster b / (BUFS_PER_EU*EUS_PER_CLUSTER).
- R5: With two outstanding producers, the order of preference is fixed: behind the src0 producer, then behind the src1 producer, then the lowest empty buffer in the src0 producer's cluster, then the lowest empty buffer in the src1 producer's cluster.
- R6: When no candidate exists, stall is 1, steer_valid is 0, and no state changes.
- R7: An accepted instruction with a destination makes that register's entry valid, points it at the chosen buffer and clears its consumer flag. This write takes precedence over a completion of the same register in the same cycle.
- R8: A completion with done_reg and done_buf clears the register's entry only if the entry names that buffer. Later readers then treat that source as ready.
- R9: Each accepted instruction adds one entry to its buffer, and each drain bit removes one. A buffer is full at BUF_DEPTH entries and empty at zero. A drain of an empty buffer is ignored. No instruction is ever steered into a full buffer.
- R10: For each outstanding source whose producer's unit differs from the chosen unit, ntfN_valid is 1 and ntfN_eu is the producer's unit. ntf_cons_eu gives the chosen unit. No notice is raised when the producer is in the same unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| src0_valid | input | 1 | Source 0 is used |
| src0_reg | input | RW | Source 0 register |
| src1_valid | input | 1 | Source 1 is used |
| src1_reg | input | RW | Source 1 register |
| dst_valid | input | 1 | Instruction writes a register |
| dst_reg | input | RW | Destination register |
| drain | input | NB | One bit per buffer: one entry left that buffer |
| done_valid | input | 1 | A producer completed |
| done_reg | input | RW | Register written by the completed producer |
| done_buf | input | BW | Buffer the completed producer occupied |
| steer_valid | output | 1 | Instruction accepted into steer_buf |
| steer_buf | output | BW | Chosen buffer |
| stall | output | 1 | Instruction presented but not accepted |
| ntf0_valid | output | 1 | Notice to the source 0 producer's unit |
| ntf0_eu | output | EW | Unit of the source 0 producer |
| ntf1_valid | output | 1 | Notice to the source 1 producer's unit |
| ntf1_eu | output | EW | Unit of the source 1 producer |
| ntf_cons_eu | output | EW | Unit that received the consumer |

## Verification
The hardest case to reach is a dependent instruction that stalls while buffers in the other cluster are still empty. Reaching it needs every buffer in the producer's cluster occupied and the producer's own slot closed, either because its consumer flag is set or because its buffer is full. The directed prologue builds this state. It fills cluster 0 with a handful of chains, closes one register's slot with a second reader, and then issues a third reader of that register. A seeded random phase with sparse drains and a small register set then keeps returning the block to crowded states, and a bench model checks every cycle.

// File: rtl/dep_steer_pkg.sv
package dep_steer_pkg;

    // Which candidate the steering decision settled on
    typedef enum logic [2:0] {
        PICK_NONE,
        PICK_ANY,
        PICK_BEHIND0,
        PICK_BEHIND1,
        PICK_CL0,
        PICK_CL1
    } pick_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dep_steer_pick.sv
module dep_steer_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/dep_steer_occ.sv
module dep_steer_occ #(
    parameter int NB    = 16,
    parameter int DEPTH = 4,
    parameter int RW    = 5,
    parameter int BW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [BW-1:0]          push_buf,
    input  logic                   push_has_dst,
    input  logic [RW-1:0]          push_dst,
    input  logic [NB-1:0]          drain,
    output logic [NB-1:0]          empty_vec,
    output logic [NB-1:0]          full_vec,
    output logic [NB-1:0]          tail_vld,
    output logic [NB-1:0][RW-1:0]  tail_reg
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NB-1:0][CW-1:0] cnt;
        logic [NB-1:0]         tvld;
        logic [NB-1:0][RW-1:0] treg;
    } occ_t;

    occ_t occ_d, occ_q;

    always_comb begin
        occ_d = occ_q;
        for (int b = 0; b < NB; b++) begin
            logic inc, dec;
            inc = push && (int'(push_buf) == b);
            dec = drain[b] && (occ_q.cnt[b] != '0);
            if (inc && !dec)      occ_d.cnt[b] = occ_q.cnt[b] + CW'(1);
            else if (dec && !inc) occ_d.cnt[b] = occ_q.cnt[b] - CW'(1);
            if (inc) begin
                occ_d.tvld[b] = push_has_dst;
                occ_d.treg[b] = push_dst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    for (genvar b = 0; b < NB; b++) begin : g_flags
        assign empty_vec[b] = (occ_q.cnt[b] == '0);
        assign full_vec[b]  = (occ_q.cnt[b] == CW'(DEPTH));
    end

    assign tail_vld = occ_q.tvld;
    assign tail_reg = occ_q.treg;

endmodule

// File: rtl/dep_steer_tab.sv
module dep_steer_tab #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int BW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd0_reg,
    output logic          rd0_vld,
    output logic [BW-1:0] rd0_buf,
    output logic          rd0_cons,
    input  logic [RW-1:0] rd1_reg,
    output logic          rd1_vld,
    output logic [BW-1:0] rd1_buf,
    output logic          rd1_cons,
    input  logic          mark_vld,
    input  logic [RW-1:0] mark_reg,
    input  logic          wr_vld,
    input  logic [RW-1:0] wr_reg,
    input  logic [BW-1:0] wr_buf,
    input  logic          done_vld,
    input  logic [RW-1:0] done_reg,
    input  logic [BW-1:0] done_buf
);

    typedef struct packed {
        logic [NREG-1:0]         vld;
        logic [NREG-1:0]         cons;
        logic [NREG-1:0][BW-1:0] bufid;
    } tab_t;

    tab_t tab_d, tab_q;

    // completion first, then consumer mark, then new writer (newest wins)
    always_comb begin
        tab_d = tab_q;
        if (done_vld && tab_q.vld[done_reg] && (tab_q.bufid[done_reg] == done_buf))
            tab_d.vld[done_reg] = 1'b0;
        if (mark_vld)
            tab_d.cons[mark_reg] = 1'b1;
        if (wr_vld) begin
            tab_d.vld[wr_reg]   = 1'b1;
            tab_d.cons[wr_reg]  = 1'b0;
            tab_d.bufid[wr_reg] = wr_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign rd0_vld  = tab_q.vld[rd0_reg];
    assign rd0_buf  = tab_q.bufid[rd0_reg];
    assign rd0_cons = tab_q.cons[rd0_reg];
    assign rd1_vld  = tab_q.vld[rd1_reg];
    assign rd1_buf  = tab_q.bufid[rd1_reg];
    assign rd1_cons = tab_q.cons[rd1_reg];

endmodule

// File: rtl/dep_steer.sv
module dep_steer
    import dep_steer_pkg::*;
#(
    parameter  int NUM_EU          = 8,
    parameter  int BUFS_PER_EU     = 2,
    parameter  int EUS_PER_CLUSTER = 4,
    parameter  int NUM_REGS        = 32,
    parameter  int BUF_DEPTH       = 4,
    localparam int NB              = NUM_EU * BUFS_PER_EU,
    localparam int BPC             = BUFS_PER_EU * EUS_PER_CLUSTER,
    localparam int BW              = idx_width(NB),
    localparam int RW              = idx_width(NUM_REGS),
    localparam int EW              = idx_width(NUM_EU)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          src0_valid,
    input  logic [RW-1:0] src0_reg,
    input  logic          src1_valid,
    input  logic [RW-1:0] src1_reg,
    input  logic          dst_valid,
    input  logic [RW-1:0] dst_reg,
    input  logic [NB-1:0] drain,
    input  logic          done_valid,
    input  logic [RW-1:0] done_reg,
    input  logic [BW-1:0] done_buf,
    output logic          steer_valid,
    output logic [BW-1:0] steer_buf,
    output logic          stall,
    output logic          ntf0_valid,
    output logic [EW-1:0] ntf0_eu,
    output logic          ntf1_valid,
    output logic [EW-1:0] ntf1_eu,
    output logic [EW-1:0] ntf_cons_eu
);

    logic [NB-1:0]         empty_vec, full_vec, tail_vld;
    logic [NB-1:0][RW-1:0] tail_reg;
    logic                  t0_vld, t0_cons, t1_vld, t1_cons;
    logic [BW-1:0]         p0_buf, p1_buf;
    logic                  src0_out, src1_out;
    logic                  behind0, behind1;
    int unsigned           cl0, cl1;
    logic [NB-1:0]         mask0, mask1;
    logic                  any_found, c0_found, c1_found;
    logic [BW-1:0]         any_idx, c0_idx, c1_idx;
    pick_e                 pick;
    logic                  mark_vld;
    logic [RW-1:0]         mark_reg;

    dep_steer_tab #(.NREG(NUM_REGS), .RW(RW), .BW(BW)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd0_reg  (src0_reg),
        .rd0_vld  (t0_vld),
        .rd0_buf  (p0_buf),
        .rd0_cons (t0_cons),
        .rd1_reg  (src1_reg),
        .rd1_vld  (t1_vld),
        .rd1_buf  (p1_buf),
        .rd1_cons (t1_cons),
        .mark_vld (mark_vld),
        .mark_reg (mark_reg),
        .wr_vld   (steer_valid && dst_valid),
        .wr_reg   (dst_reg),
        .wr_buf   (steer_buf),
        .done_vld (done_valid),
        .done_reg (done_reg),
        .done_buf (done_buf)
    );

    dep_steer_occ #(.NB(NB), .DEPTH(BUF_DEPTH), .RW(RW), .BW(BW)) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (steer_valid),
        .push_buf     (steer_buf),
        .push_has_dst (dst_valid),
        .push_dst     (dst_reg),
        .drain        (drain),
        .empty_vec    (empty_vec),
        .full_vec     (full_vec),
        .tail_vld     (tail_vld),
        .tail_reg     (tail_reg)
    );

    // outstanding sources and the slot behind each producer
    assign src0_out = in_valid && src0_valid && t0_vld;
    assign src1_out = in_valid && src1_valid && t1_vld;
    assign behind0  = src0_out && !t0_cons && tail_vld[p0_buf]
                      && (tail_reg[p0_buf] == src0_reg) && !full_vec[p0_buf];
    assign behind1  = src1_out && !t1_cons && tail_vld[p1_buf]
                      && (tail_reg[p1_buf] == src1_reg) && !full_vec[p1_buf];
    assign cl0 = int'(p0_buf) / BPC;
    assign cl1 = int'(p1_buf) / BPC;

    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign mask0[b] = empty_vec[b] && ((b / BPC) == cl0);
        assign mask1[b] = empty_vec[b] && ((b / BPC) == cl1);
    end

    dep_steer_pick #(.N(NB), .IW(BW)) u_pick_any (
        .req(empty_vec), .found(any_found), .idx(any_idx));
    dep_steer_pick #(.N(NB), .IW(BW)) u_pick_c0 (
        .req(mask0), .found(c0_found), .idx(c0_idx));
    dep_steer_pick #(.N(NB), .IW(BW)) u_pick_c1 (
        .req(mask1), .found(c1_found), .idx(c1_idx));

    // priority: behind src0, behind src1, src0 cluster, src1 cluster
    always_comb begin
        pick = PICK_NONE;
        if (in_valid) begin
            if (!src0_out && !src1_out) begin
                if (any_found) pick = PICK_ANY;
            end else if (behind0) begin
                pick = PICK_BEHIND0;
            end else if (behind1) begin
                pick = PICK_BEHIND1;
            end else if (src0_out && c0_found) begin
                pick = PICK_CL0;
            end else if (src1_out && c1_found) begin
                pick = PICK_CL1;
            end
        end
    end

    always_comb begin
        case (pick)
            PICK_ANY:     steer_buf = any_idx;
            PICK_BEHIND0: steer_buf = p0_buf;
            PICK_BEHIND1: steer_buf = p1_buf;
            PICK_CL0:     steer_buf = c0_idx;
            PICK_CL1:     steer_buf = c1_idx;
            default:      steer_buf = '0;
        endcase
    end

    assign steer_valid = (pick != PICK_NONE);
    assign stall       = in_valid && (pick == PICK_NONE);
    assign mark_vld    = (pick == PICK_BEHIND0) || (pick == PICK_BEHIND1);
    assign mark_reg    = (pick == PICK_BEHIND1) ? src1_reg : src0_reg;

    assign ntf_cons_eu = EW'(int'(steer_buf) / BUFS_PER_EU);
    assign ntf0_eu     = EW'(int'(p0_buf) / BUFS_PER_EU);
    assign ntf1_eu     = EW'(int'(p1_buf) / BUFS_PER_EU);
    assign ntf0_valid  = steer_valid && src0_out && (ntf0_eu != ntf_cons_eu);
    assign ntf1_valid  = steer_valid && src1_out && (ntf1_eu != ntf_cons_eu);

endmodule

// File: rtl/dep_steer_chk.sv
module dep_steer_chk #(
    parameter int NB  = 16,
    parameter int BPC = 8,
    parameter int BW  = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          steer_valid,
    input logic [BW-1:0] steer_buf,
    input logic          ntf0_valid,
    input logic          ntf1_valid,
    input logic [NB-1:0] empty_vec,
    input logic [NB-1:0] full_vec,
    input logic          src0_out,
    input logic          src1_out,
    input logic [BW-1:0] p0_buf,
    input logic [BW-1:0] p1_buf
);

    // R9
    no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        steer_valid |-> !full_vec[steer_buf]);

    // R9
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        steer_valid |=> !empty_vec[$past(steer_buf)]);

    // R2
    ready_to_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !src0_out && !src1_out && (|empty_vec))
        |-> (steer_valid && empty_vec[steer_buf]));

    // R4
    one_prod_affine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_valid && src0_out && !src1_out)
        |-> ((int'(steer_buf) / BPC) == (int'(p0_buf) / BPC)));

    // R5
    two_prod_affine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_valid && src0_out && src1_out)
        |-> (((int'(steer_buf) / BPC) == (int'(p0_buf) / BPC))
          || ((int'(steer_buf) / BPC) == (int'(p1_buf) / BPC))));

    // R10
    notice_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf0_valid || ntf1_valid) |-> steer_valid);

endmodule

bind dep_steer dep_steer_chk #(.NB(NB), .BPC(BPC), .BW(BW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .steer_valid (steer_valid),
    .steer_buf   (steer_buf),
    .ntf0_valid  (ntf0_valid),
    .ntf1_valid  (ntf1_valid),
    .empty_vec   (empty_vec),
    .full_vec    (full_vec),
    .src0_out    (src0_out),
    .src1_out    (src1_out),
    .p0_buf      (p0_buf),
    .p1_buf      (p1_buf)
);

// File: tb/dep_steer_bench.sv
module dep_steer_bench;

    localparam int CLK_P = 10;
    localparam int NEU   = 8;
    localparam int BPE   = 2;
    localparam int EPC   = 4;
    localparam int NREG  = 32;
    localparam int DEP   = 4;
    localparam int NB    = NEU * BPE;
    localparam int BPC   = BPE * EPC;
    localparam int BW    = 4;
    localparam int RW    = 5;
    localparam int EW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, src0_valid = 1'b0, src1_valid = 1'b0, dst_valid = 1'b0;
    logic [RW-1:0] src0_reg = '0, src1_reg = '0, dst_reg = '0, done_reg = '0;
    logic [NB-1:0] drain = '0;
    logic          done_valid = 1'b0;
    logic [BW-1:0] done_buf = '0;
    logic          steer_valid, stall, ntf0_valid, ntf1_valid;
    logic [BW-1:0] steer_buf;
    logic [EW-1:0] ntf0_eu, ntf1_eu, ntf_cons_eu;

    dep_steer #(.NUM_EU(NEU), .BUFS_PER_EU(BPE), .EUS_PER_CLUSTER(EPC),
                .NUM_REGS(NREG), .BUF_DEPTH(DEP)) u_dep_steer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src0_valid(src0_valid), .src0_reg(src0_reg),
        .src1_valid(src1_valid), .src1_reg(src1_reg),
        .dst_valid(dst_valid), .dst_reg(dst_reg), .drain(drain),
        .done_valid(done_valid), .done_reg(done_reg), .done_buf(done_buf),
        .steer_valid(steer_valid), .steer_buf(steer_buf), .stall(stall),
        .ntf0_valid(ntf0_valid), .ntf0_eu(ntf0_eu),
        .ntf1_valid(ntf1_valid), .ntf1_eu(ntf1_eu), .ntf_cons_eu(ntf_cons_eu));

    always #(CLK_P / 2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    // bench model of the requirements
    bit m_vld  [NREG];
    bit m_cons [NREG];
    int m_buf  [NREG];
    int m_cnt  [NB];
    bit m_tv   [NB];
    int m_tr   [NB];

    // model decision: kind 0 none,1 any,2 behind0,3 behind1,4 cl0,5 cl1
    int  e_kind, e_buf;
    bit  o0, o1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int low_empty(input int cl);
        for (int b = 0; b < NB; b++)
            if (m_cnt[b] == 0 && (cl < 0 || b / BPC == cl)) return b;
        return -1;
    endfunction

    function automatic bit slot_free(input int r);
        int b;
        b = m_buf[r];
        return m_vld[r] && !m_cons[r] && m_tv[b] && (m_tr[b] == r) && (m_cnt[b] < DEP);
    endfunction

    task automatic model_eval();
        int c;
        o0 = in_valid && src0_valid && m_vld[src0_reg];
        o1 = in_valid && src1_valid && m_vld[src1_reg];
        e_kind = 0; e_buf = 0;
        if (in_valid) begin
            if (!o0 && !o1) begin
                c = low_empty(-1);
                if (c >= 0) begin e_kind = 1; e_buf = c; end
            end else if (o0 && slot_free(src0_reg)) begin
                e_kind = 2; e_buf = m_buf[src0_reg];
            end else if (o1 && slot_free(src1_reg)) begin
                e_kind = 3; e_buf = m_buf[src1_reg];
            end else begin
                c = o0 ? low_empty(m_buf[src0_reg] / BPC) : -1;
                if (c >= 0) begin e_kind = 4; e_buf = c; end
                else begin
                    c = o1 ? low_empty(m_buf[src1_reg] / BPC) : -1;
                    if (c >= 0) begin e_kind = 5; e_buf = c; end
                end
            end
        end
    endtask

    task automatic model_update();
        for (int b = 0; b < NB; b++)
            if (drain[b] && m_cnt[b] > 0) m_cnt[b]--;
        if (done_valid && m_vld[done_reg] && m_buf[done_reg] == int'(done_buf))
            m_vld[done_reg] = 1'b0;
        if (e_kind != 0) begin
            if (e_kind == 2) m_cons[src0_reg] = 1'b1;
            if (e_kind == 3) m_cons[src1_reg] = 1'b1;
            m_cnt[e_buf]++;
            m_tv[e_buf] = dst_valid;
            m_tr[e_buf] = int'(dst_reg);
            if (dst_valid) begin
                m_vld[dst_reg]  = 1'b1;
                m_cons[dst_reg] = 1'b0;
                m_buf[dst_reg]  = e_buf;
            end
        end
    endtask

    task automatic compare();
        string tg;
        bit    n0, n1;
        case (e_kind)
            0: tg = in_valid ? "R6" : "R1";
            1: tg = "R2";
            2, 3: tg = (o0 && o1) ? "R5" : "R3";
            default: tg = (o0 && o1) ? "R5" : "R4";
        endcase
        chk(steer_valid == (e_kind != 0), tg, int'(steer_valid), int'(e_kind != 0));
        chk(stall == (in_valid && e_kind == 0), "R6", int'(stall), int'(in_valid && e_kind == 0));
        if (e_kind != 0) begin
            chk(int'(steer_buf) == e_buf, tg, int'(steer_buf), e_buf);
            n0 = o0 && (m_buf[src0_reg] / BPE != e_buf / BPE);
            n1 = o1 && (m_buf[src1_reg] / BPE != e_buf / BPE);
            chk(ntf0_valid == n0 && ntf1_valid == n1, "R10",
                int'({ntf0_valid, ntf1_valid}), int'({n0, n1}));
            chk(int'(ntf_cons_eu) == e_buf / BPE, "R10", int'(ntf_cons_eu), e_buf / BPE);
            if (n0) chk(int'(ntf0_eu) == m_buf[src0_reg] / BPE, "R10", int'(ntf0_eu), m_buf[src0_reg] / BPE);
            if (n1) chk(int'(ntf1_eu) == m_buf[src1_reg] / BPE, "R10", int'(ntf1_eu), m_buf[src1_reg] / BPE);
        end else begin
            chk(!ntf0_valid && !ntf1_valid, "R10", int'({ntf0_valid, ntf1_valid}), 0);
        end
    endtask

    // lit: -1 none, -2 expect stall, >=0 expected buffer
    task automatic step(input bit iv, input bit s0v, input int s0, input bit s1v, input int s1,
                        input bit dv, input int d, input logic [NB-1:0] drn,
                        input bit cv, input int cr, input int cb,
                        input int lit, input string ltag);
        @(negedge clk);
        in_valid = iv; src0_valid = s0v; src0_reg = RW'(s0);
        src1_valid = s1v; src1_reg = RW'(s1);
        dst_valid = dv; dst_reg = RW'(d); drain = drn;
        done_valid = cv; done_reg = RW'(cr); done_buf = BW'(cb);
        #1;
        model_eval();
        compare();
        if (lit == -2) chk(stall == 1'b1, ltag, int'(stall), 1);
        else if (lit >= 0) chk(steer_valid && int'(steer_buf) == lit, ltag, int'(steer_buf), lit);
        model_update();
    endtask

    task automatic idle(input logic [NB-1:0] drn, input bit cv, input int cr, input int cb);
        step(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, drn, cv, cr, cb, -1, "");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) begin m_vld[i] = 0; m_cons[i] = 0; m_buf[i] = 0; end
        for (int b = 0; b < NB; b++) begin m_cnt[b] = 0; m_tv[b] = 0; m_tr[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle outputs then first pick
        idle('0, 1'b0, 0, 0);
        chk(!steer_valid && !stall, "R1", int'({steer_valid, stall}), 0);
        step(1, 0, 0, 0, 0, 1, 1, '0, 0, 0, 0, 0, "R1");        // r1 -> buf0
        step(1, 1, 1, 0, 0, 1, 2, '0, 0, 0, 0, 0, "R3");        // behind r1
        step(1, 1, 1, 0, 0, 1, 3, '0, 0, 0, 0, 1, "R4");        // flag set -> cluster empty
        step(1, 1, 1, 0, 0, 1, 4, '0, 0, 0, 0, 2, "R10");       // other unit, notice
        step(1, 0, 0, 0, 0, 1, 1, '0, 0, 0, 0, 3, "R7");        // rewrite r1 -> buf3
        step(1, 1, 1, 0, 0, 1, 6, '0, 0, 0, 0, 3, "R7");        // behind new r1 writer
        idle('0, 1'b1, 2, 0);                                    // r2 completes
        step(1, 1, 2, 0, 0, 0, 0, '0, 0, 0, 0, 4, "R8");        // r2 now ready
        step(1, 0, 0, 0, 0, 1, 5, '0, 0, 0, 0, 5, "R9");
        step(1, 1, 5, 0, 0, 1, 5, '0, 0, 0, 0, 5, "R9");
        step(1, 1, 5, 0, 0, 1, 5, '0, 0, 0, 0, 5, "R9");
        step(1, 1, 5, 0, 0, 1, 5, '0, 0, 0, 0, 5, "R9");        // buf5 now full
        step(1, 1, 5, 0, 0, 1, 5, '0, 0, 0, 0, 6, "R9");        // full -> spill in cluster
        idle(NB'((1 << 5) | (1 << 4)), 1'b0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, '0, 0, 0, 0, 4, "R9");        // drained buf4 empty again
        idle(NB'(1 << 8), 1'b0, 0, 0);                            // drain of empty buf8
        step(1, 0, 0, 0, 0, 0, 0, '0, 0, 0, 0, 7, "R9");
        step(1, 0, 0, 0, 0, 0, 0, '0, 0, 0, 0, 8, "R9");        // buf8 still empty
        step(1, 1, 1, 0, 0, 1, 9, '0, 0, 0, 0, -2, "R6");       // cluster0 full, slot taken
        step(1, 1, 1, 0, 0, 1, 9, '0, 0, 0, 0, -2, "R6");       // unchanged after stall
        step(1, 1, 6, 1, 3, 1, 10, '0, 0, 0, 0, 3, "R5");       // behind src0 producer
        step(1, 1, 1, 1, 3, 0, 0, '0, 0, 0, 0, 1, "R5");        // src0 closed -> behind src1
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [NB-1:0] drn;
            int r;
            drn = '0;
            for (int b = 0; b < NB; b++) drn[b] = ($urandom % 9) == 0;
            r = $urandom % 8;
            step(($urandom % 6) != 0, ($urandom % 3) != 0, $urandom % 8,
                 ($urandom % 2) != 0, $urandom % 8, ($urandom % 4) != 0, $urandom % 8,
                 drn, ($urandom % 4) == 0, r,
                 (($urandom % 4) != 0) ? m_buf[r] : int'($urandom % NB), -1, "");
        end
        ended = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule